// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffer

This block is a small queue of prefetched cache lines that sits next to a first-level cache and is probed in the same cycle as the cache. Prefetched lines stay in the queue and are never written into the cache, so a prefetch that turns out to be useless cannot evict anything the cache holds. Only the oldest entry, the head, can serve a lookup. When a lookup hits the head, that line is handed back in the same cycle and the entry is released. The freed slot is then used to request exactly one more line, the next line in sequence after the newest one already queued.

When the cache misses and the head does not match, the block treats the access as the start of a new stream. It discards the whole queue and refills it with the lines that follow the missing line, one request per accepted cycle, until the queue is full. The lower level answers requests in the order it received them. Each answer fills the oldest entry that is still waiting for its data. Answers to requests made before a restart are recognised and thrown away.

Top module: `stream_pfb`

## Requirements
- R1: Out of reset the queue is empty: `lk_hit`, `lk_stall` and `req_valid` are all 0.
- R2: A lookup with `lk_l1_miss`=1 that does not match the head restarts the stream at line L (the looked-up line). On the following cycles the block requests lines L+1, L+2, … in increasing order, one per accepted request. Requests stop once DEPTH entries are queued.
- R3: A lookup whose line equals the head entry's line, with that entry's data present, raises `lk_hit` combinationally in the same cycle and drives that line's data on `lk_data`. The entry is popped at the clock edge. `lk_stall` stays 0.
- R4: A lookup that matches a queued line other than the head is not a hit. If `lk_l1_miss`=1 it restarts the stream, just as a line that is not queued at all would.
- R5: A lookup with `lk_l1_miss`=0 that does not match the head leaves the queue, the head and the request stream unchanged.
- R6: Each pop of the head frees one slot, which causes exactly one further request, for the line one above the newest line queued so far.
- R7: A lookup that matches the head while the head's data is still outstanding gives `lk_stall`=1 and `lk_hit`=0. It does not restart the stream, even with `lk_l1_miss`=1. The same lookup hits once the fill has arrived.
- R8: Fill responses are taken in request order and written into the oldest entry still waiting for data. Responses to requests issued before a restart are discarded.
- R9: While `req_valid`=1 and `req_ready`=0, `req_valid` stays high and `req_line` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup probe this cycle |
| lk_line | input | ADDR_W | Line address being looked up |
| lk_l1_miss | input | 1 | The parallel cache lookup missed |
| lk_hit | output | 1 | Head entry matched with data present |
| lk_stall | output | 1 | Head entry matched, data still outstanding |
| lk_data | output | DATA_W | Line data of the head entry |
| req_valid | output | 1 | Fill request to the lower level |
| req_ready | input | 1 | Lower level accepts the request |
| req_line | output | ADDR_W | Line address requested |
| rsp_valid | input | 1 | Fill data returned (in request order) |
| rsp_data | input | DATA_W | Returned line data |

## Verification
The hardest situation to reach from the ports is a restart that happens while earlier fills are still in flight. In that case stale data must not land in the entries of the new stream. The bench's lower-level model can hold back its responses. It lets four requests go out unanswered, then causes a restart with a miss to an unrelated line, and only then releases the responses. The first lines of the new stream must come back with their own data, not the data of the abandoned stream. The stall case is reached the same way, by probing the head while responses are held back.

// File: rtl/stream_pfb_pkg.sv
// Shared types for the stream prefetch buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package stream_pfb_pkg;

    // Outcome of one lookup probe against the queue head.
    typedef enum logic [2:0] {
        PROBE_IDLE,     // no lookup this cycle
        PROBE_HIT,      // head matches, data present: consume it
        PROBE_STALL,    // head matches, data still in flight
        PROBE_RESTART,  // cache and head both missed: new stream
        PROBE_PASS      // cache hit, head miss: nothing to do
    } probe_e;

endpackage

// File: rtl/stream_pfb_slots.sv
// Entry storage of the prefetch queue: per slot a line tag, a valid bit,
// a data-present bit and the line data. Exposes one read port (the head).
// Assumes the controller never allocates into a valid slot, never pops a
// slot that lacks data, and never fills a slot that is not waiting.
module stream_pfb_slots #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              alloc_en,
    input  logic [PTR_W-1:0]  alloc_idx,
    input  logic [ADDR_W-1:0] alloc_tag,
    input  logic              fill_en,
    input  logic [PTR_W-1:0]  fill_idx,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              pop_en,
    input  logic [PTR_W-1:0]  pop_idx,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_ready,
    output logic [ADDR_W-1:0] rd_tag,
    output logic [DATA_W-1:0] rd_data
);

    logic              vld [DEPTH];
    logic              arr [DEPTH];
    logic [ADDR_W-1:0] tag [DEPTH];
    logic [DATA_W-1:0] dat [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Per-slot state: clear, allocate, pop and fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[g] <= 1'b0;
                arr[g] <= 1'b0;
                tag[g] <= '0;
                dat[g] <= '0;
            end else if (clr) begin
                vld[g] <= 1'b0;
                arr[g] <= 1'b0;
            end else begin
                if (alloc_en && alloc_idx == PTR_W'(g)) begin
                    vld[g] <= 1'b1;
                    arr[g] <= 1'b0;
                    tag[g] <= alloc_tag;
                end else if (pop_en && pop_idx == PTR_W'(g)) begin
                    vld[g] <= 1'b0;
                    arr[g] <= 1'b0;
                end
                if (fill_en && fill_idx == PTR_W'(g)) begin
                    arr[g] <= 1'b1;
                    dat[g] <= fill_data;
                end
            end
        end
    end

    // Head read port.
    always_comb begin
        rd_valid = vld[rd_idx];
        rd_ready = arr[rd_idx];
        rd_tag   = tag[rd_idx];
        rd_data  = dat[rd_idx];
    end

endmodule

// File: rtl/stream_pfb_fetch.sv
// Request generator: holds the next sequential line to fetch, counts fills
// in flight and how many of them belong to an abandoned stream.
// Assumes the lower level answers every accepted request once, in order.
module stream_pfb_fetch #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [ADDR_W-1:0] restart_line,
    input  logic              room,
    input  logic              req_ready,
    input  logic              rsp_valid,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_line,
    output logic              accept,
    output logic              rsp_live
);

    logic              active_q;
    logic [ADDR_W-1:0] next_q;
    logic [CNT_W-1:0]  inflight_q;
    logic [CNT_W-1:0]  drop_q;

    // Request when a stream runs, a slot is free and the fill budget allows.
    always_comb begin
        req_valid = active_q && room && (inflight_q < CNT_W'(DEPTH)) && !restart;
        req_line  = next_q;
        accept    = req_valid && req_ready;
        rsp_live  = rsp_valid && (drop_q == '0) && !restart;
    end

    // Stream position, fills in flight and stale fills still to discard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= 1'b0;
            next_q     <= '0;
            inflight_q <= '0;
            drop_q     <= '0;
        end else if (restart) begin
            active_q   <= 1'b1;
            next_q     <= restart_line + 1'b1;
            inflight_q <= inflight_q - CNT_W'(rsp_valid);
            drop_q     <= inflight_q - CNT_W'(rsp_valid);
        end else begin
            if (accept) begin
                next_q <= next_q + 1'b1;
            end
            inflight_q <= inflight_q + CNT_W'(accept) - CNT_W'(rsp_valid);
            if (rsp_valid && drop_q != '0) begin
                drop_q <= drop_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/stream_pfb.sv
// Sequential stream prefetch buffer beside a first-level cache.
// Probed in parallel with the cache; only the head entry can hit. A miss in
// both restarts the stream at the missing line plus one. Each pop frees a
// slot that the fetch unit refills with the next sequential line.
// Assumes in-order fill responses and that a stalled lookup is repeated.
module stream_pfb
    import stream_pfb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_line,
    input  logic              lk_l1_miss,
    output logic              lk_hit,
    output logic              lk_stall,
    output logic [DATA_W-1:0] lk_data,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_line,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [PTR_W-1:0]  head_q, tail_q, fill_q;
    logic [CNT_W-1:0]  count_q;
    logic              h_valid, h_ready;
    logic [ADDR_W-1:0] h_tag;
    logic [DATA_W-1:0] h_data;
    logic              head_match, restart, accept, rsp_live, room;
    probe_e            probe;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Classify the current lookup against the head entry.
    always_comb begin
        head_match = lk_valid && h_valid && (h_tag == lk_line);
        probe      = PROBE_IDLE;
        if (lk_valid) begin
            if (head_match) begin
                probe = h_ready ? PROBE_HIT : PROBE_STALL;
            end else begin
                probe = lk_l1_miss ? PROBE_RESTART : PROBE_PASS;
            end
        end
    end

    // Lookup results and queue-level conditions.
    always_comb begin
        lk_hit   = (probe == PROBE_HIT);
        lk_stall = (probe == PROBE_STALL);
        lk_data  = h_data;
        restart  = (probe == PROBE_RESTART);
        room     = (count_q < CNT_W'(DEPTH));
    end

    // Ring pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            head_q  <= '0;
            tail_q  <= '0;
            fill_q  <= '0;
            count_q <= '0;
        end else begin
            if (lk_hit)   head_q <= bump(head_q);
            if (accept)   tail_q <= bump(tail_q);
            if (rsp_live) fill_q <= bump(fill_q);
            count_q <= count_q + CNT_W'(accept) - CNT_W'(lk_hit);
        end
    end

    stream_pfb_slots #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)
    ) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (restart),
        .alloc_en  (accept),
        .alloc_idx (tail_q),
        .alloc_tag (req_line),
        .fill_en   (rsp_live),
        .fill_idx  (fill_q),
        .fill_data (rsp_data),
        .pop_en    (lk_hit),
        .pop_idx   (head_q),
        .rd_idx    (head_q),
        .rd_valid  (h_valid),
        .rd_ready  (h_ready),
        .rd_tag    (h_tag),
        .rd_data   (h_data)
    );

    stream_pfb_fetch #(
        .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
    ) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (restart),
        .restart_line (lk_line),
        .room         (room),
        .req_ready    (req_ready),
        .rsp_valid    (rsp_valid),
        .req_valid    (req_valid),
        .req_line     (req_line),
        .accept       (accept),
        .rsp_live     (rsp_live)
    );

endmodule

// File: rtl/stream_pfb_chk.sv
// Protocol and queue checks for stream_pfb, attached by bind.
// Assumes the parameters match the bound instance.
module stream_pfb_chk #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4,
    parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              lk_l1_miss,
    input logic              lk_hit,
    input logic              lk_stall,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_line,
    input logic [PTR_W-1:0]  head_q,
    input logic [CNT_W-1:0]  count_q
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> (req_line == $past(req_line)) && (req_valid || (lk_valid && lk_l1_miss))); // R9

    AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid || (req_line == $past(req_line) + 1'b1)); // R2

    AST_POP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |=> head_q == (($past(head_q) == PTR_W'(DEPTH - 1)) ? '0 : $past(head_q) + 1'b1)); // R3

    AST_RESTART_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && lk_l1_miss && !lk_hit && !lk_stall |=> count_q == '0); // R4

    AST_STALL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        lk_stall |=> count_q != '0); // R7

endmodule

bind stream_pfb stream_pfb_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_l1_miss (lk_l1_miss),
    .lk_hit     (lk_hit),
    .lk_stall   (lk_stall),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_line   (req_line),
    .head_q     (head_q),
    .count_q    (count_q)
);

// File: tb/sim_stream_pfb.sv
// Self-checking bench for stream_pfb with an in-order lower-level model.
module sim_stream_pfb;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int DEPTH = 4;
    localparam int LAT = 2;

    typedef struct packed {
        logic [1:0]  op;     // 0: idle arg cycles, 1: probe line arg
        logic [15:0] arg;
        logic        miss;
        logic        exp_hit;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{2'd1, 16'h0100, 1'b1, 1'b0, 4'd2},  // R2 empty queue, restart
        '{2'd0, 16'd10,   1'b0, 1'b0, 4'd0},
        '{2'd1, 16'h0101, 1'b1, 1'b1, 4'd3},  // R3 head hit
        '{2'd1, 16'h0102, 1'b1, 1'b1, 4'd3},  // R3 back to back
        '{2'd1, 16'h0104, 1'b1, 1'b0, 4'd4},  // R4 not at head
        '{2'd0, 16'd12,   1'b0, 1'b0, 4'd0},
        '{2'd1, 16'h0200, 1'b0, 1'b0, 4'd5},  // R5 cache hit only
        '{2'd1, 16'h0105, 1'b0, 1'b1, 4'd5},  // R5 stream untouched
        '{2'd1, 16'h0106, 1'b1, 1'b1, 4'd3},
        '{2'd1, 16'h0107, 1'b1, 1'b1, 4'd3},
        '{2'd1, 16'h0108, 1'b1, 1'b1, 4'd3},
        '{2'd0, 16'd12,   1'b0, 1'b0, 4'd0},
        '{2'd1, 16'h0109, 1'b1, 1'b1, 4'd6}   // R6 refill continues
    };

    logic          clk = 1'b0;
    logic          rst_n, lk_valid, lk_l1_miss, lk_hit, lk_stall;
    logic [AW-1:0] lk_line, req_line;
    logic [DW-1:0] lk_data, rsp_data;
    logic          req_valid, req_ready, rsp_valid;

    always #5 clk = ~clk;

    stream_pfb #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_line(lk_line),
        .lk_l1_miss(lk_l1_miss), .lk_hit(lk_hit), .lk_stall(lk_stall),
        .lk_data(lk_data), .req_valid(req_valid), .req_ready(req_ready),
        .req_line(req_line), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int wd = 0;
    bit done = 1'b0;

    logic [AW-1:0] mq_line [32];
    int            mq_due [32];
    int            mq_n = 0;
    bit            rsp_en = 1'b1;

    logic          s_hit, s_stall, s_rv;
    logic [DW-1:0] s_data;
    logic [AW-1:0] s_rl;

    function automatic logic [DW-1:0] line_of(input logic [AW-1:0] a);
        return {~a, a};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One clock: drive the model's response, sample before the edge, record.
    task automatic step();
        if (rsp_en && mq_n > 0 && mq_due[0] <= cyc) begin
            rsp_valid = 1'b1;
            rsp_data  = line_of(mq_line[0]);
            for (int k = 0; k < 31; k++) begin
                mq_line[k] = mq_line[k+1];
                mq_due[k]  = mq_due[k+1];
            end
            mq_n--;
        end else begin
            rsp_valid = 1'b0;
            rsp_data  = '0;
        end
        #8;
        s_hit = lk_hit; s_stall = lk_stall; s_data = lk_data;
        s_rv = req_valid; s_rl = req_line;
        if (req_valid && req_ready) begin
            mq_line[mq_n] = req_line;
            mq_due[mq_n]  = cyc + LAT;
            mq_n++;
        end
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic probe(input logic [AW-1:0] a, input logic m);
        lk_valid = 1'b1; lk_line = a; lk_l1_miss = m;
    endtask

    task automatic idle(input int n);
        lk_valid = 1'b0; lk_l1_miss = 1'b0; lk_line = '0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        wd++;
        if (wd > 4000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 4000 cycles", wd);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; req_ready = 1'b1; rsp_valid = 1'b0; rsp_data = '0;
        lk_valid = 1'b0; lk_l1_miss = 1'b0; lk_line = '0;
        #1;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 hit", s_hit, 0);
        chk("R1 stall", s_stall, 0);
        chk("R1 req_valid", s_rv, 0);

        // Vector table
        foreach (TBL[v]) begin
            if (TBL[v].op == 2'd0) begin
                idle(int'(TBL[v].arg));
            end else begin
                probe(TBL[v].arg, TBL[v].miss);
                step();
                chk($sformatf("R%0d hit line %0h", TBL[v].req, TBL[v].arg), s_hit, TBL[v].exp_hit);
                chk($sformatf("R%0d stall line %0h", TBL[v].req, TBL[v].arg), s_stall, 0);
                if (TBL[v].exp_hit)
                    chk($sformatf("R%0d data line %0h", TBL[v].req, TBL[v].arg), s_data, line_of(TBL[v].arg));
            end
        end

        // R2 burst on restart, R7 stall, R6 one refill per pop
        idle(12);
        rsp_en = 1'b0;
        probe(16'h0300, 1'b1);
        step();
        chk("R2 no hit on restart", s_hit, 0);
        lk_valid = 1'b0;
        for (int k = 1; k <= DEPTH; k++) begin
            step();
            chk("R2 req_valid", s_rv, 1);
            chk("R2 req_line", s_rl, 16'h0300 + k);
        end
        step();
        chk("R2 stop when full", s_rv, 0);
        probe(16'h0301, 1'b1);
        step();
        chk("R7 stall", s_stall, 1);
        chk("R7 no hit", s_hit, 0);
        step();
        chk("R7 still stall, no restart", s_stall, 1);
        rsp_en = 1'b1;
        begin
            bit got = 1'b0;
            for (int t = 0; t < 10 && !got; t++) begin
                step();
                if (s_hit) begin
                    got = 1'b1;
                    chk("R7 data after stall", s_data, line_of(16'h0301));
                end
            end
            chk("R7 hit after fill", got, 1);
        end
        idle(1);
        chk("R6 refill request", s_rv, 1);
        chk("R6 refill line", s_rl, 16'h0305);
        idle(1);
        chk("R6 exactly one refill", s_rv, 0);

        // R8 stale fills after restart are discarded
        idle(12);
        rsp_en = 1'b0;
        probe(16'h0400, 1'b1);
        step();
        idle(6);
        probe(16'h0500, 1'b1);
        step();
        rsp_en = 1'b1;
        idle(16);
        probe(16'h0501, 1'b1);
        step();
        chk("R8 hit new stream", s_hit, 1);
        chk("R8 data new stream", s_data, line_of(16'h0501));
        probe(16'h0502, 1'b1);
        step();
        chk("R8 second line data", s_data, line_of(16'h0502));

        // R9 request held under backpressure
        idle(12);
        req_ready = 1'b0;
        probe(16'h0600, 1'b1);
        step();
        lk_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R9 req held", s_rv, 1);
            chk("R9 line stable", s_rl, 16'h0601);
        end
        req_ready = 1'b1;
        step();
        chk("R9 accepted line", s_rl, 16'h0601);
        step();
        chk("R9 next line", s_rl, 16'h0602);

        idle(2);
        finish_run();
    end

endmodule